// File: doc/BRIEF.md
# GPIO Bank Register Controller

This block owns one bank of 32 general-purpose I/O lines and exposes them through a small 32-bit register port. Software sets each line's direction with a 2-bit code. The codes for the lower sixteen lines sit in one direction register, and the codes for the upper sixteen sit in another register at a non-adjacent offset. A line drives its pad only when two things are true: its direction code selects output, and its bit in a separate output-enable register is set. A chip with two banks places two copies of this block.

The register port is a plain strobe interface. No data stream crosses the block edge, so it has no valid/ready handshake and no back-pressure. A write strobe updates a register on the clock edge where the strobe is high. A read strobe captures the addressed value into a registered read bus, which is valid one cycle later. The read bus holds that value until the next read strobe. Input pads pass through a two-flop synchroniser before they can be read. A read of the data register merges the stored values of driving lines with the synchronised pad levels of all other lines.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous active-high reset, both direction registers, the output-enable register, the output data, `pin_oe`, `pin_out` and `rdata` are all zero, so every line is an input.
- R2: The direction code of line i (0..15) is bits [2i+1:2i] of the register at offset 0x00. The code of line 16+j (j = 0..15) is bits [2j+1:2j] of the register at offset 0x14. Both registers read back exactly as written.
- R3: Direction code 0 means input and code 1 means output. Codes 2 and 3 are stored and read back unchanged, but the line behaves as an input and `pin_oe` for that line stays 0.
- R4: `pin_oe[i]` is 1 exactly when line i has direction code 1 and bit i of the output-enable register (offset 0x18) is 1. A change takes effect in the cycle after the write edge.
- R5: `pin_out[i]` always equals bit i of the output data register (offset 0x04), whether or not the line is enabled.
- R6: A read of offset 0x04 returns the stored output bit for each line whose `pin_oe` is 1, and the synchronised pad level for every other line. A pad change set up before edge k is first seen by a read strobe sampled at edge k+2.
- R7: Reads of any offset other than 0x00, 0x04, 0x14 and 0x18 return zero. Writes to such offsets change no register.
- R8: `rdata` is loaded only on an edge where `rd_en` is high and holds its value otherwise. A read and a write to the same offset in the same cycle return the value from before the write.
- R9: A write takes effect on the edge of its strobe, and a read strobe in the following cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Per-pad drive enable, 1 = drive |

## Verification
Several checks run on every cycle. The assertions confirm that a reserved code written to a low-bank direction field never turns on that pad's driver. They confirm that output-enable bits cleared by a write drop `pin_oe` on the next cycle, and that data writes show up on `pin_out` one cycle later. They also confirm that writes to unmapped offsets leave every register untouched, that reads of unmapped offsets return zero, that `rdata` holds between strobes, and that the synchroniser output trails the pads by exactly two edges.

Other behaviours only the bench scenarios can show. These are the exact placement of each line's field across the two split registers, the merged readback of driving and non-driving lines, the cycle at which a pad change first becomes readable, and read-before-write ordering within one cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int LINES   = 32;
  localparam int DIR_W   = 2;
  localparam int HALF    = LINES / 2;
  localparam int REG_W   = 32;

  typedef enum logic [DIR_W-1:0] {
    DIR_IN   = 2'd0,
    DIR_OUT  = 2'd1,
    DIR_RSV2 = 2'd2,
    DIR_RSV3 = 2'd3
  } dir_code_e;

  localparam logic [7:0] OFF_DIR_LO = 8'h00;
  localparam logic [7:0] OFF_DATA   = 8'h04;
  localparam logic [7:0] OFF_DIR_HI = 8'h14;
  localparam logic [7:0] OFF_OE     = 8'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

  // warm-up counter: two non-reset edges before the delay check applies
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R6: synchronised value trails the pad by two edges
  p_sync_delay_r6: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  dir_lo,
  output logic [REG_W-1:0]  dir_hi,
  output logic [LINES-1:0]  oe_bits,
  output logic [LINES-1:0]  dout
);
  logic hit_dir_lo, hit_dir_hi, hit_oe, hit_data;

  assign hit_dir_lo = (addr == ADDR_W'(OFF_DIR_LO));
  assign hit_dir_hi = (addr == ADDR_W'(OFF_DIR_HI));
  assign hit_oe     = (addr == ADDR_W'(OFF_OE));
  assign hit_data   = (addr == ADDR_W'(OFF_DATA));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_lo  <= '0;
      dir_hi  <= '0;
      oe_bits <= '0;
      dout    <= '0;
    end else if (wr_en) begin
      if (hit_dir_lo) dir_lo  <= wdata;
      if (hit_dir_hi) dir_hi  <= wdata;
      if (hit_oe)     oe_bits <= wdata[LINES-1:0];
      if (hit_data)   dout    <= wdata[LINES-1:0];
    end
  end

  // R7: a write to an unmapped offset leaves all state untouched
  p_ignored_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(hit_dir_lo || hit_dir_hi || hit_oe || hit_data))
      |=> ($stable(dir_lo) && $stable(dir_hi) && $stable(oe_bits) && $stable(dout)));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
  import gpio_bank_pkg::*;
(
  input  logic [REG_W-1:0] dir_lo,
  input  logic [REG_W-1:0] dir_hi,
  input  logic [LINES-1:0] oe_bits,
  input  logic [LINES-1:0] dout,
  output logic [LINES-1:0] pin_oe,
  output logic [LINES-1:0] pin_out
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    dir_code_e code;
    if (i < HALF) begin : g_lo
      assign code = dir_code_e'(dir_lo[DIR_W*i +: DIR_W]);
    end else begin : g_hi
      assign code = dir_code_e'(dir_hi[DIR_W*(i-HALF) +: DIR_W]);
    end
    // reserved codes fall through to input: only DIR_OUT may drive
    assign pin_oe[i] = (code == DIR_OUT) && oe_bits[i];
  end

  assign pin_out = dout;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe
);
  logic [REG_W-1:0] dir_lo, dir_hi;
  logic [LINES-1:0] oe_bits, dout, sync_in;
  logic [REG_W-1:0] rd_mux;

  gpio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dir_lo(dir_lo), .dir_hi(dir_hi), .oe_bits(oe_bits), .dout(dout)
  );

  gpio_sync #(.WIDTH(LINES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_in)
  );

  gpio_drive u_drive (
    .dir_lo(dir_lo), .dir_hi(dir_hi), .oe_bits(oe_bits), .dout(dout),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  always_comb begin
    case (addr)
      ADDR_W'(OFF_DIR_LO): rd_mux = dir_lo;
      ADDR_W'(OFF_DIR_HI): rd_mux = dir_hi;
      ADDR_W'(OFF_OE):     rd_mux = oe_bits;
      ADDR_W'(OFF_DATA):   rd_mux = (pin_oe & dout) | (~pin_oe & sync_in);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R7: unmapped reads return zero one cycle later
  p_unmapped_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != ADDR_W'(OFF_DIR_LO) && addr != ADDR_W'(OFF_DIR_HI)
           && addr != ADDR_W'(OFF_OE) && addr != ADDR_W'(OFF_DATA))
      |=> (rdata == '0));

  // R8: read bus holds between strobes
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R4: enable bits cleared by a write stop driving on the next cycle
  p_oe_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_OE)) |=> ((pin_oe & ~$past(wdata)) == '0));

  // R5: data writes reach the pads the next cycle
  p_pin_out_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_DATA)) |=> (pin_out == $past(wdata)));

  // R3: a reserved code written to a low-bank field never drives
  for (genvar i = 0; i < HALF; i++) begin : g_rsv_chk
    p_reserved_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(OFF_DIR_LO) && wdata[DIR_W*i+1]) |=> !pin_oe[i]);
  end
endmodule

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata, pin_in, pin_out, pin_oe;
  int total = 0;
  int bad = 0;

  localparam logic [7:0] A_DLO = 8'h00, A_DAT = 8'h04, A_DHI = 8'h14, A_OE = 8'h18;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    rd(A_DLO, v); check("R1 dir_lo", v, 32'h0);
    rd(A_DHI, v); check("R1 dir_hi", v, 32'h0);
    rd(A_OE, v);  check("R1 oe", v, 32'h0);
  endtask

  task automatic t_dir_map();
    logic [31:0] v;
    wr(A_DLO, 32'h0000_0004);
    rd(A_DLO, v); check("R9 R2 dir_lo readback", v, 32'h0000_0004);
    wr(A_DHI, 32'h4000_0000);
    wr(A_OE, 32'hFFFF_FFFF);
    check("R2 R4 line1/line31 drive", pin_oe, 32'h8000_0002);
    rd(A_DHI, v); check("R2 dir_hi readback", v, 32'h4000_0000);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(A_DHI, 32'h0);
    wr(A_DLO, 32'h0000_001E);
    check("R3 reserved codes not driving", pin_oe, 32'h0000_0004);
    rd(A_DLO, v); check("R3 reserved stored", v, 32'h0000_001E);
  endtask

  task automatic t_gating();
    wr(A_DLO, 32'h5555_5555);
    wr(A_OE, 32'h0000_00F0);
    check("R4 partial enable", pin_oe, 32'h0000_00F0);
    wr(A_OE, 32'hFFFF_FFFF);
    check("R4 upper lines input", pin_oe, 32'h0000_FFFF);
    wr(A_OE, 32'h0);
    wr(A_DAT, 32'hA5A5_A5A5);
    check("R5 pin_out without enable", pin_out, 32'hA5A5_A5A5);
    check("R4 none enabled", pin_oe, 32'h0);
  endtask

  task automatic t_data_read();
    logic [31:0] v;
    wr(A_OE, 32'hFFFF_FFFF);
    wr(A_DAT, 32'h1234_ABCD);
    pin_in = 32'hFFFF_0000;
    idle(2);
    rd(A_DAT, v); check("R6 merge high pads", v, 32'hFFFF_ABCD);
    pin_in = 32'h0000_FFFF;
    idle(2);
    rd(A_DAT, v); check("R6 merge low pads", v, 32'h0000_ABCD);
  endtask

  task automatic t_sync_latency();
    logic [31:0] v;
    wr(A_OE, 32'h0);
    pin_in = 32'h0;
    idle(3);
    pin_in = 32'hC3C3_3C3C;
    idle(1);
    rd(A_DAT, v); check("R6 not yet visible", v, 32'h0);
    rd(A_DAT, v); check("R6 visible after two edges", v, 32'hC3C3_3C3C);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(A_OE, 32'h0000_0011);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R7 unmapped read", v, 32'h0);
    rd(A_OE, v);  check("R7 oe untouched", v, 32'h0000_0011);
    rd(A_DHI, v); check("R7 dir_hi untouched", v, 32'h0);
  endtask

  task automatic t_read_order();
    logic [31:0] v;
    rd(A_OE, v);
    wr(A_OE, 32'h0000_0022);
    idle(2);
    check("R8 rdata holds", rdata, 32'h0000_0011);
    wr_en = 1'b1; rd_en = 1'b1; addr = A_OE; wdata = 32'h0000_0044;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R8 read before write", rdata, 32'h0000_0022);
    rd(A_OE, v); check("R9 new value next read", v, 32'h0000_0044);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_dir_map();
    t_reserved();
    t_gating();
    t_data_read();
    t_sync_latency();
    t_unmapped();
    t_read_order();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule